// File: doc/BRIEF.md
# GPIO Combined Interrupt with Debounce

A small bank of general-purpose I/O pins, each with its own configuration register that selects direction, value inversion and participation in a shared interrupt. An input pin is synchronised into the clock domain and optionally inverted. An output pin drives a stored data bit through the same inversion and asserts its output enable.

Every input pin whose interrupt participation is set contributes its (possibly inverted) level to a single OR-ed interrupt request. A filter-control register chooses whether that request goes straight to the interrupt output or through a debounce filter. The filter counts pulses of a millisecond-rate tick and rejects any request pulse that lasts one tick period or less.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin configuration register reads 0x01, the filter-control register reads 0x00, the data register reads 0 for any pin whose synchronised level is 0, every pin_oe_o bit is 0 and irq_o is 0.
- R2: Pin configuration register i is at address i. Bit 0 set makes pin i an input (pin_oe_o[i]=0); bit 0 clear makes it an output (pin_oe_o[i]=1).
- R3: Bit 1 of a pin configuration register inverts the pin: an output pin drives pin_o[i] = data bit i XOR bit 1, and reading the data register (address NUM_PINS+1) returns, for an input pin, pin_i[i] XOR bit 1 after two clock cycles of synchronisation, and for an output pin the stored data bit.
- R4: The raw interrupt request is the OR, over every pin with bit 0 and bit 2 both set, of pin_i XOR bit 1.
- R5: Bits 7 to 3 of a pin configuration register, and all bits except bit 3 of the filter-control register (address NUM_PINS), read as zero and ignore writes.
- R6: With filter-control bit 3 clear, irq_o follows the raw interrupt request two clock cycles after a pin change.
- R7: With filter-control bit 3 set, a raw request pulse lasting one tick period or less, at any phase relative to tick_i, never reaches irq_o.
- R8: With filter-control bit 3 set, a raw request level held across two tick_i pulses is passed to irq_o, for both assertion and release.
- R9: A pin in output mode never contributes to the interrupt request, whatever its bit 2 and its pin_i level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | One-cycle millisecond tick |
| pin_i | input | NUM_PINS | Pin input levels |
| pin_o | output | NUM_PINS | Pin output levels |
| pin_oe_o | output | NUM_PINS | Pin output enables |
| irq_o | output | 1 | Common interrupt request |

## Verification
The case that matters most is a tick that falls in the same cycle as the filtered request's raw level changing. A pulse that ends exactly on a tick must still be rejected, and a level that begins just before a tick must still need a second tick before it passes. The bench sweeps a one-tick-period pulse across every phase offset against the tick generator. It flags a failure if irq_o is seen high at any sampled cycle of the window. Long holds at the same offsets are checked for propagation in both directions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned CFG_W   = 3;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned FILT_EN_BIT = 3;

  typedef struct packed {
    logic irq_en;  // bit 2
    logic inv;     // bit 1
    logic dir_in;  // bit 0
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{irq_en: 1'b0, inv: 1'b0, dir_in: 1'b1};
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  pin_cfg_t wcfg_i,
  input  logic     data_i,
  input  logic     pin_i,
  output logic     pin_o,
  output logic     pin_oe_o,
  output pin_cfg_t cfg_o,
  output logic     level_o,
  output logic     irq_req_o
);
  pin_cfg_t cfg_q;
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else if (wr_i) cfg_q <= wcfg_i;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else sync_q <= pin_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign cfg_o     = cfg_q;
  assign level_o   = sync_q[SYNC_STAGES-1] ^ cfg_q.inv;
  assign pin_oe_o  = ~cfg_q.dir_in;
  assign pin_o     = data_i ^ cfg_q.inv;
  assign irq_req_o = cfg_q.dir_in & cfg_q.irq_en & level_o;

  assert_cfg_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (pin_oe_o == ~$past(wcfg_i.dir_in)));
  assert_out_no_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> !irq_req_o);
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned DEB_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  assert_filt_tick_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(filt_q));
  assert_filt_toward_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && raw_i == filt_q) |=> $stable(filt_q));
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(DEB_TICKS));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned AW          = 4,
  parameter int unsigned DEB_TICKS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam logic [AW-1:0] FILT_ADDR = AW'(NUM_PINS);
  localparam logic [AW-1:0] DATA_ADDR = AW'(NUM_PINS + 1);

  pin_cfg_t            cfg   [NUM_PINS];
  logic [NUM_PINS-1:0] level, req;
  logic [NUM_PINS-1:0] data_q;
  logic                filt_en_q;
  logic                raw_irq, filt_irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      filt_en_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == DATA_ADDR) data_q <= wdata_i[NUM_PINS-1:0];
      if (addr_i == FILT_ADDR) filt_en_q <= wdata_i[FILT_EN_BIT];
    end
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_en_i && addr_i == AW'(i)),
        .wcfg_i   (pin_cfg_t'(wdata_i[CFG_W-1:0])),
        .data_i   (data_q[i]),
        .pin_i    (pin_i[i]),
        .pin_o    (pin_o[i]),
        .pin_oe_o (pin_oe_o[i]),
        .cfg_o    (cfg[i]),
        .level_o  (level[i]),
        .irq_req_o(req[i])
      );
    end
  endgenerate

  assign raw_irq = |req;

  gpio_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .raw_i (raw_irq),
    .filt_o(filt_irq)
  );

  assign irq_o = filt_en_q ? filt_irq : raw_irq;

  always_comb begin
    rdata_o = '0;
    if (addr_i < FILT_ADDR) begin
      for (int i = 0; i < NUM_PINS; i++)
        if (addr_i == AW'(i)) rdata_o[CFG_W-1:0] = cfg[i];
    end else if (addr_i == FILT_ADDR) begin
      rdata_o[FILT_EN_BIT] = filt_en_q;
    end else if (addr_i == DATA_ADDR) begin
      for (int i = 0; i < NUM_PINS; i++)
        rdata_o[i] = cfg[i].dir_in ? level[i] : data_q[i];
    end
  end

  assert_bypass_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filt_en_q && irq_o) |-> (|(~pin_oe_o)));
  assert_filt_ctrl_rsvd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == FILT_ADDR) |-> (rdata_o[REG_W-1:FILT_EN_BIT+1] == '0 &&
                                rdata_o[FILT_EN_BIT-1:0] == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int TP = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic tick = 0;
  logic [NP-1:0] pin_in = 0, pin_out, pin_oe;
  logic irq;

  int checks = 0, errors = 0;
  int tcnt = 0;
  bit seen_hi = 0;
  logic [2:0] cfg_m [NP];
  logic [NP-1:0] data_m;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq));

  always @(negedge clk) begin
    tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
    if (irq) seen_hi = 1;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_irq(input logic [NP-1:0] p);
    logic r = 0;
    for (int i = 0; i < NP; i++)
      if (cfg_m[i][0] && cfg_m[i][2]) r |= p[i] ^ cfg_m[i][1];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = ~cfg_m[i][0];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = data_m[i] ^ cfg_m[i][1];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_rd(input logic [NP-1:0] p);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = cfg_m[i][0] ? (p[i] ^ cfg_m[i][1]) : data_m[i];
    return r;
  endfunction

  task automatic wait_phase(input int off);
    @(negedge clk);
    while (tcnt != 0) @(negedge clk);
    wait_cyc(off);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NP; i++) cfg_m[i] = 3'b001;
    data_m = 0;
    wait_cyc(3);
    // R1 reset state, sampled while reset still held
    chk("R1 oe", pin_oe, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    wait_cyc(2);
    for (int i = 0; i < NP; i++) begin rd(AW'(i), d); chk("R1 cfg", d, 8'h01); end
    rd(AW'(NP), d); chk("R1 filt", d, 8'h00);
    rd(AW'(NP + 1), d); chk("R1 data", d, 8'h00);

    // R5 reserved bits
    wr(0, 8'hFF); rd(0, d); chk("R5 cfg rsvd", d, 8'h07);
    wr(AW'(NP), 8'hF7); rd(AW'(NP), d); chk("R5 filt rsvd", d, 8'h00);
    wr(AW'(NP), 8'h08); rd(AW'(NP), d); chk("R5 filt bit3", d, 8'h08);
    wr(AW'(NP), 8'h00);
    wr(0, 8'h01);

    // R9 directed: output pin with irq enable never requests
    wr(1, 8'h04); cfg_m[1] = 3'b100;
    pin_in = 4'b0010; wait_cyc(4);
    chk("R9 out pin", irq, 0);
    chk("R2 out oe", pin_oe, 4'b0010);
    // R6 bypass timing: two cycles after change
    wr(2, 8'h05); cfg_m[2] = 3'b101;
    @(negedge clk); pin_in = 4'b0110;
    @(negedge clk); chk("R6 one cycle", irq, 0);
    @(negedge clk); chk("R6 two cycles", irq, 1);
    pin_in = 0; wait_cyc(3);

    // random config, pins, data with filter bypassed: R2 R3 R4 R9
    for (int it = 0; it < 60; it++) begin
      for (int i = 0; i < NP; i++) begin
        cfg_m[i] = 3'($urandom);
        wr(AW'(i), {5'($urandom), cfg_m[i]});
      end
      data_m = NP'($urandom);
      wr(AW'(NP + 1), {4'($urandom), data_m});
      pin_in = NP'($urandom);
      wait_cyc(3);
      chk("R4 irq", irq, exp_irq(pin_in));
      chk("R2 oe", pin_oe, exp_oe());
      chk("R3 out", pin_out, exp_out());
      rd(AW'(NP + 1), d); chk("R3 rd", d, {4'h0, exp_rd(pin_in)});
    end

    // filter tests: pin0 input, irq enabled, others off
    for (int i = 0; i < NP; i++) begin cfg_m[i] = 3'b001; wr(AW'(i), 8'h01); end
    wr(0, 8'h05); cfg_m[0] = 3'b101;
    pin_in = 0;
    wr(AW'(NP), 8'h08);
    wait_cyc(4 * TP);
    for (int off = 0; off < TP; off++) begin
      // R7 one-period pulse at every phase
      wait_phase(off);
      seen_hi = 0;
      pin_in[0] = 1; wait_cyc(TP); pin_in[0] = 0;
      wait_cyc(3 * TP);
      chk("R7 pulse rejected", seen_hi, 0);
      // R8 long hold passes, release passes
      wait_phase(off);
      pin_in[0] = 1; wait_cyc(3 * TP + 3);
      chk("R8 assert", irq, 1);
      pin_in[0] = 0; wait_cyc(3 * TP + 3);
      chk("R8 release", irq, 0);
    end
    // R7 short inverted glitch on held-high request
    pin_in[0] = 1; wait_cyc(4 * TP);
    wait_phase(3); pin_in[0] = 0; wait_cyc(4); pin_in[0] = 1;
    wait_cyc(2 * TP); chk("R7 low glitch", irq, 1);
    // R6 back to bypass follows raw
    pin_in[0] = 0; wr(AW'(NP), 8'h00); wait_cyc(3);
    chk("R6 bypass low", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule